// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Aggregator

This block watches one or more banks of already-synchronized input pins, finds rising and falling transitions on each pin, and latches each selected transition into a per-pin status bit. Software picks the edges to watch through write-one-to-set and write-one-to-clear enable registers, one pair for rising edges and one pair for falling edges. It clears captured events by writing ones back to the status register.

Each bank's status word is split into a lower and an upper half. Each half drives its own level-sensitive interrupt line. A global line-enable register gates every line. Line 2k carries the lower half of bank k and line 2k+1 carries the upper half. A line stays high while any status bit of its half is set and its enable bit is on.

The register port is a plain single-cycle strobe interface. A write takes effect at the clock edge where `bus_wr` is sampled high. A read strobe is answered one cycle later with `bus_rvalid`. The bus never stalls, so there is no back-pressure.

Top module: `gpio_eirq_agg`

## Requirements
- R1: After reset every edge enable, every status bit and every line-enable bit is zero, every interrupt line is low, and `bus_rvalid` is low.
- R2: Writing ones to a bank's rising-set register (bank base + 0x04) enables rising detection on those bits, and writing ones to rising-clear (base + 0x08) disables it. Zero bits leave the enable unchanged. Both addresses read back the current rising-enable word.
- R3: The falling-set register (base + 0x0C) and the falling-clear register (base + 0x10) behave the same way for falling-edge enables. Both addresses read back the current falling-enable word.
- R4: A 0-to-1 transition on a pin whose rising enable is set sets that pin's status bit at the clock edge that first samples the new level. A transition on a pin with its rising enable off captures nothing.
- R5: A 1-to-0 transition on a pin whose falling enable is set sets that pin's status bit at the same point. A transition on a pin with its falling enable off captures nothing.
- R6: A pin with both enables set captures either direction of transition.
- R7: Writing to the status register (base + 0x14) clears every bit written as one and leaves the bits written as zero set. Status bits otherwise stay set.
- R8: When a new enabled edge and a clearing write hit the same status bit at the same clock edge, the bit ends up set.
- R9: Interrupt line 2k is high exactly while line-enable bit 2k is set and any status bit [HALF-1:0] of bank k is set. Line 2k+1 is the same for status bits [BANK_W-1:HALF]. A line stays high for as long as that condition holds.
- R10: The line-enable register sits at byte address 0x08 and holds one bit per interrupt line. A line whose enable bit is clear stays low whatever its status is.
- R11: Bank k occupies byte addresses 0x10 + 0x28*k onward. Reading base + 0x00 returns the current pin levels of that bank.
- R12: A read strobe returns its data on `bus_rdata` with `bus_rvalid` high in the following cycle. `bus_rvalid` is low in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | BANK_W | Write data |
| bus_rdata | output | BANK_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pins | input | NUM_BANKS*BANK_W | Synchronized pin levels, bank k at bits [k*BANK_W +: BANK_W] |
| irq | output | 2*NUM_BANKS | Level interrupt lines, two per bank |

## Verification
A wrong enable or a wrong stored previous pin level shows up at the next transition of the affected pin. The status bit is then missing or spurious one clock after the pin moves, and a status read one cycle later exposes it. A status bit that drops on its own, or a clearing write that does not clear, changes the matching interrupt line in the very cycle it happens. The line therefore gives the earliest view, and the read path confirms it per bit. The sweep moves every pin of every bank in both directions under all four enable combinations, so a fault in any single bit position or edge polarity is caught.

// File: rtl/gpio_eirq_pkg.sv
package gpio_eirq_pkg;

  // Byte address of the global line-enable register.
  localparam logic [31:0] LINE_EN_ADDR = 32'h08;
  // First bank base and distance between bank windows.
  localparam logic [31:0] BANK0_BASE   = 32'h10;
  localparam logic [31:0] BANK_STRIDE  = 32'h28;
  // Size of the decoded part of one bank window.
  localparam logic [31:0] BANK_SPAN    = 32'h18;

  typedef enum logic [2:0] {
    SEL_LEVEL    = 3'd0,
    SEL_RISE_SET = 3'd1,
    SEL_RISE_CLR = 3'd2,
    SEL_FALL_SET = 3'd3,
    SEL_FALL_CLR = 3'd4,
    SEL_STATUS   = 3'd5,
    SEL_NONE     = 3'd7
  } reg_sel_e;

  function automatic logic [31:0] bank_base(input int b);
    return BANK0_BASE + 32'(b) * BANK_STRIDE;
  endfunction

  // Offset order inside a bank window is fixed by the register map.
  function automatic reg_sel_e off_to_sel(input logic [31:0] off);
    case (off)
      32'h00:  return SEL_LEVEL;
      32'h04:  return SEL_RISE_SET;
      32'h08:  return SEL_RISE_CLR;
      32'h0C:  return SEL_FALL_SET;
      32'h10:  return SEL_FALL_CLR;
      32'h14:  return SEL_STATUS;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_eirq_decode.sv
module gpio_eirq_decode
  import gpio_eirq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_hit,
  output reg_sel_e             sel,
  output logic                 line_en_hit
);

  logic [31:0] addr_ext;
  assign addr_ext = 32'(addr);

  assign line_en_hit = (addr_ext == LINE_EN_ADDR);

  always_comb begin
    bank_hit = '0;
    sel      = SEL_NONE;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if ((addr_ext >= bank_base(b)) &&
          (addr_ext < (bank_base(b) + BANK_SPAN)) &&
          (addr_ext[1:0] == 2'b00)) begin
        bank_hit[b] = 1'b1;
        sel         = off_to_sel(addr_ext - bank_base(b));
      end
    end
  end

endmodule

// File: rtl/gpio_eirq_edge.sv
module gpio_eirq_edge #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  output logic [WIDTH-1:0] hits
);

  logic [WIDTH-1:0] level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level;
  end

  // Per-pin comparison of the present level against last cycle's level.
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic went_up, went_down;
    assign went_up   =  level[i] & ~level_q[i];
    assign went_down = ~level[i] &  level_q[i];
    assign hits[i]   = (went_up & rise_en[i]) | (went_down & fall_en[i]);
  end

endmodule

// File: rtl/gpio_eirq_bank.sv
module gpio_eirq_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] level,
  input  logic [BANK_W-1:0] wdata,
  input  logic              we_rise_set,
  input  logic              we_rise_clr,
  input  logic              we_fall_set,
  input  logic              we_fall_clr,
  input  logic              we_status,
  output logic [BANK_W-1:0] rise_en,
  output logic [BANK_W-1:0] fall_en,
  output logic [BANK_W-1:0] status,
  output logic              pend_lo,
  output logic              pend_hi
);

  localparam int HALF = BANK_W / 2;

  logic [BANK_W-1:0] hits;
  logic [BANK_W-1:0] clr_mask;

  gpio_eirq_edge #(.WIDTH(BANK_W)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .level   (level),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .hits    (hits)
  );

  always_ff @(posedge clk) begin
    if (rst)              rise_en <= '0;
    else if (we_rise_set) rise_en <= rise_en | wdata;
    else if (we_rise_clr) rise_en <= rise_en & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)              fall_en <= '0;
    else if (we_fall_set) fall_en <= fall_en | wdata;
    else if (we_fall_clr) fall_en <= fall_en & ~wdata;
  end

  assign clr_mask = we_status ? wdata : '0;

  // A fresh edge is ORed in after the clear, so it survives a same-cycle clear.
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_mask) | hits;
  end

  assign pend_lo = |status[HALF-1:0];
  assign pend_hi = |status[BANK_W-1:HALF];

endmodule

// File: rtl/gpio_eirq_agg.sv
module gpio_eirq_agg
  import gpio_eirq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  output logic                        bus_rvalid,
  input  logic [NUM_BANKS*BANK_W-1:0] pins,
  output logic [2*NUM_BANKS-1:0]      irq
);

  localparam int NUM_LINES = 2 * NUM_BANKS;
  localparam int ALL_W     = NUM_BANKS * BANK_W;

  logic [NUM_BANKS-1:0] bank_hit;
  reg_sel_e             sel;
  logic                 line_en_hit;

  logic [NUM_LINES-1:0] bank_en;
  logic [ALL_W-1:0]     rise_en_all;
  logic [ALL_W-1:0]     fall_en_all;
  logic [ALL_W-1:0]     status_all;
  logic [NUM_BANKS-1:0] pend_lo;
  logic [NUM_BANKS-1:0] pend_hi;
  logic [BANK_W-1:0]    rd_next;

  gpio_eirq_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr        (bus_addr),
    .bank_hit    (bank_hit),
    .sel         (sel),
    .line_en_hit (line_en_hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_here;
    assign wr_here = bus_wr & bank_hit[b];

    gpio_eirq_bank #(.BANK_W(BANK_W)) u_bank (
      .clk         (clk),
      .rst         (rst),
      .level       (pins[b*BANK_W +: BANK_W]),
      .wdata       (bus_wdata),
      .we_rise_set (wr_here & (sel == SEL_RISE_SET)),
      .we_rise_clr (wr_here & (sel == SEL_RISE_CLR)),
      .we_fall_set (wr_here & (sel == SEL_FALL_SET)),
      .we_fall_clr (wr_here & (sel == SEL_FALL_CLR)),
      .we_status   (wr_here & (sel == SEL_STATUS)),
      .rise_en     (rise_en_all[b*BANK_W +: BANK_W]),
      .fall_en     (fall_en_all[b*BANK_W +: BANK_W]),
      .status      (status_all[b*BANK_W +: BANK_W]),
      .pend_lo     (pend_lo[b]),
      .pend_hi     (pend_hi[b])
    );

    assign irq[2*b]   = bank_en[2*b]   & pend_lo[b];
    assign irq[2*b+1] = bank_en[2*b+1] & pend_hi[b];
  end

  always_ff @(posedge clk) begin
    if (rst)                         bank_en <= '0;
    else if (bus_wr && line_en_hit)  bank_en <= bus_wdata[NUM_LINES-1:0];
  end

  always_comb begin
    rd_next = '0;
    if (line_en_hit) rd_next[NUM_LINES-1:0] = bank_en;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        case (sel)
          SEL_LEVEL:                  rd_next = pins[b*BANK_W +: BANK_W];
          SEL_RISE_SET, SEL_RISE_CLR: rd_next = rise_en_all[b*BANK_W +: BANK_W];
          SEL_FALL_SET, SEL_FALL_CLR: rd_next = fall_en_all[b*BANK_W +: BANK_W];
          SEL_STATUS:                 rd_next = status_all[b*BANK_W +: BANK_W];
          default:                    rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_next;
    end
  end

endmodule

// File: rtl/gpio_eirq_agg_chk.sv
module gpio_eirq_agg_chk
  import gpio_eirq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [BANK_W-1:0]           bus_wdata,
  input logic                        bus_rvalid,
  input logic [NUM_BANKS*BANK_W-1:0] pins,
  input logic [2*NUM_BANKS-1:0]      irq,
  input logic [2*NUM_BANKS-1:0]      bank_en,
  input logic [NUM_BANKS*BANK_W-1:0] rise_en_all,
  input logic [NUM_BANKS*BANK_W-1:0] fall_en_all,
  input logic [NUM_BANKS*BANK_W-1:0] status_all
);

  localparam int ALL_W = NUM_BANKS * BANK_W;

  logic [ALL_W-1:0] pins_q;
  logic [ALL_W-1:0] clr_vec;
  logic [ALL_W-1:0] rset_vec;
  logic [ALL_W-1:0] fset_vec;
  logic [ALL_W-1:0] exp_hits;
  logic [31:0]      a32;

  assign a32 = 32'(bus_addr);

  always_ff @(posedge clk) begin
    if (rst) pins_q <= '0;
    else     pins_q <= pins;
  end

  always_comb begin
    clr_vec  = '0;
    rset_vec = '0;
    fset_vec = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_wr && a32 == bank_base(b) + 32'h14) clr_vec[b*BANK_W +: BANK_W]  = bus_wdata;
      if (bus_wr && a32 == bank_base(b) + 32'h04) rset_vec[b*BANK_W +: BANK_W] = bus_wdata;
      if (bus_wr && a32 == bank_base(b) + 32'h0C) fset_vec[b*BANK_W +: BANK_W] = bus_wdata;
    end
  end

  assign exp_hits = (rise_en_all & pins & ~pins_q) | (fall_en_all & ~pins & pins_q);

  AST_LINE_GATED: assert property (@(posedge clk) disable iff (rst)
    (irq & ~bank_en) == '0);  // R10

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status_all) & ~$past(clr_vec) & ~status_all) == '0));  // R7

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_all & $past(exp_hits)) == $past(exp_hits)));  // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_all & ~$past(status_all) & ~$past(exp_hits)) == '0));  // R4

  AST_RISE_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rise_en_all & $past(rset_vec)) == $past(rset_vec)));  // R2

  AST_FALL_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((fall_en_all & $past(fset_vec)) == $past(fset_vec)));  // R3

  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);  // R12

  AST_RVALID_ONLY_RD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);  // R12

endmodule

bind gpio_eirq_agg gpio_eirq_agg_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W),
  .ADDR_W    (ADDR_W)
) u_chk (.*);

// File: tb/gpio_eirq_agg_test.sv
`timescale 1ns/1ps
module gpio_eirq_agg_test;

  localparam int NB = 2;
  localparam int W  = 32;
  localparam int AW = 8;
  localparam int NL = 2 * NB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic          bus_rvalid;
  logic [NB*W-1:0] pins = '0;
  logic [NL-1:0] irq;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_eirq_agg #(.NUM_BANKS(NB), .BANK_W(W), .ADDR_W(AW)) uut (
    .clk, .rst, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
    .bus_rdata, .bus_rvalid, .pins, .irq
  );

  // Register addresses per the map in the requirements (R11 bases, R2/R3/R7 offsets).
  function automatic logic [AW-1:0] ra(input int b, input int off);
    return AW'(16 + b * 40 + off);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Tasks start and end at a falling edge.
  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    chk("R12 rvalid after read", W'(bus_rvalid), W'(1));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    logic [W-1:0] bit_v;
    logic [W-1:0] e;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    chk("R1 irq", W'(irq), '0);
    chk("R1 rvalid", W'(bus_rvalid), '0);
    for (int b = 0; b < NB; b++) begin
      rd(ra(b, 'h14), d); chk("R1 status", d, '0);
      rd(ra(b, 'h04), d); chk("R1 rise enable", d, '0);
      rd(ra(b, 'h0C), d); chk("R1 fall enable", d, '0);
    end
    rd(AW'(8), d); chk("R1 line enable", d, '0);
    idle(1);
    chk("R12 rvalid low when idle", W'(bus_rvalid), '0);

    // R11: level readback
    pins = {32'hA5A5_0F0F, 32'h1234_8765};
    idle(1);
    rd(ra(0, 0), d); chk("R11 level bank0", d, 32'h1234_8765);
    rd(ra(1, 0), d); chk("R11 level bank1", d, 32'hA5A5_0F0F);
    pins = '0;
    idle(2);
    rd(ra(0, 'h14), d); chk("R4 no capture with enables off", d, '0);

    // R2: rising enable set/clear
    wr(ra(0, 'h04), 32'h0000_00F0);
    rd(ra(0, 'h04), d); chk("R2 set addr readback", d, 32'h0000_00F0);
    rd(ra(0, 'h08), d); chk("R2 clr addr readback", d, 32'h0000_00F0);
    wr(ra(0, 'h04), 32'h0000_000F);
    rd(ra(0, 'h04), d); chk("R2 zeros unaffected on set", d, 32'h0000_00FF);
    wr(ra(0, 'h08), 32'h0000_0030);
    rd(ra(0, 'h04), d); chk("R2 clear", d, 32'h0000_00CF);
    wr(ra(0, 'h08), '1);

    // R3: falling enable set/clear
    wr(ra(1, 'h0C), 32'h8000_0001);
    rd(ra(1, 'h10), d); chk("R3 clr addr readback", d, 32'h8000_0001);
    wr(ra(1, 'h0C), 32'h0100_0000);
    rd(ra(1, 'h0C), d); chk("R3 zeros unaffected on set", d, 32'h8100_0001);
    wr(ra(1, 'h10), 32'h8000_0000);
    rd(ra(1, 'h0C), d); chk("R3 clear", d, 32'h0100_0001);
    wr(ra(1, 'h10), '1);

    // R4/R5/R6 sweep: every pin, every enable combination, both directions
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < W; i++) begin
        for (int mode = 0; mode < 4; mode++) begin
          bit_v = W'(1) << i;
          wr(ra(b, 'h08), '1);
          wr(ra(b, 'h10), '1);
          if (mode[0]) wr(ra(b, 'h04), bit_v);
          if (mode[1]) wr(ra(b, 'h0C), bit_v);
          pins[b*W +: W] = bit_v;
          idle(1);
          chk("R10 line low with enables off", W'(irq), '0);
          e = mode[0] ? bit_v : '0;
          rd(ra(b, 'h14), d);
          chk(mode == 3 ? "R6 rise captured" : "R4 rise", d, e);
          wr(ra(b, 'h14), '1);
          pins[b*W +: W] = '0;
          idle(1);
          e = mode[1] ? bit_v : '0;
          rd(ra(b, 'h14), d);
          chk(mode == 3 ? "R6 fall captured" : "R5 fall", d, e);
          wr(ra(b, 'h14), '1);
        end
      end
    end

    // R7: write-one-to-clear leaves zero bits set
    wr(ra(0, 'h04), '1);
    pins[31:0] = 32'h0000_0303;
    idle(1);
    wr(ra(0, 'h14), 32'h0000_0201);
    rd(ra(0, 'h14), d); chk("R7 partial clear", d, 32'h0000_0102);
    wr(ra(0, 'h14), '1);
    pins = '0;
    idle(1);

    // R8: edge and clear on the same bit in the same cycle
    wr(ra(0, 'h08), '1);
    wr(ra(0, 'h04), 32'h0000_0060);
    pins[31:0] = 32'h0000_0040;
    idle(1);
    bus_wr = 1'b1; bus_addr = ra(0, 'h14); bus_wdata = 32'h0000_0060;
    pins[31:0] = 32'h0000_0060;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(ra(0, 'h14), d); chk("R8 edge beats clear", d, 32'h0000_0020);
    wr(ra(0, 'h14), '1);
    pins = '0;
    idle(1);

    // R9/R10: line grouping and gating
    wr(ra(0, 'h04), '1);
    wr(ra(1, 'h04), '1);
    wr(AW'(8), '0);
    pins[3] = 1'b1;
    idle(1);
    chk("R10 gated line", W'(irq), '0);
    wr(AW'(8), 32'h1);
    chk("R9 lower half line", W'(irq), W'(4'b0001));
    pins[20] = 1'b1;
    idle(1);
    wr(AW'(8), 32'h3);
    chk("R9 both halves", W'(irq), W'(4'b0011));
    wr(AW'(8), 32'h2);
    chk("R10 lower gated", W'(irq), W'(4'b0010));
    idle(5);
    chk("R9 level held", W'(irq), W'(4'b0010));
    wr(AW'(8), 32'h3);
    wr(ra(0, 'h14), 32'h0000_0008);
    chk("R9 clears with half", W'(irq), W'(4'b0010));
    pins[W + 16] = 1'b1;
    idle(1);
    wr(AW'(8), 32'hF);
    chk("R9 bank1 upper line", W'(irq), W'(4'b1010));
    rd(AW'(8), d); chk("R10 line enable readback", d, 32'h0000_000F);
    wr(ra(0, 'h14), '1);
    wr(ra(1, 'h14), '1);
    chk("R9 all cleared", W'(irq), '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule